// File: doc/BRIEF.md
# Asynchronous Parallel Memory Read Controller

This block lets logic on a synchronous clock read words from an asynchronous parallel memory that has an active-low device select (`mem_ce_n`) and an active-low output gate (`mem_oe_n`). A client offers an address with a valid/ready handshake. The controller drives the address, selects the device at once, and opens the output gate later, so that both the address path and the gate path are satisfied at the same moment. One cycle after that point it captures the data bus, returns the word with a one-cycle strobe and closes both enables. It then stays busy for the bus float time, so that no other bus owner can start driving while the memory outputs are still switching off.

Wait lengths come from three access-speed classes picked by a `grade` input that is sampled only when a request is accepted. Each class sets an address/select-to-data time and a shorter gate-to-data time. Each time is turned into a cycle count by rounding up against the clock period parameter. When the controller has no access in progress, it keeps the device deselected with the output gate closed, which is the memory's low-power standby state.

Top module: `amem_reader`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `req_ready` is 1, `mem_ce_n` and `mem_oe_n` are 1, and `rsp_valid` is 0.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. From the next cycle `req_ready` is 0 until the release wait ends. A `req_valid` seen while `req_ready` is 0 starts nothing.
- R3: In the cycle after acceptance, `mem_addr` equals the accepted address and `mem_ce_n` is 0. The address stays unchanged for as long as `mem_ce_n` is 0.
- R4: `grade` sets the select-to-data time TA and the gate-to-data time TO: 0 gives 120/60 ns, 1 gives 150/80 ns, and 2 or 3 give 200/100 ns. With A = ceil(TA/period) and O = ceil(TO/period), `mem_oe_n` falls A-O cycles after `mem_ce_n` falls.
- R5: `rsp_valid` is high for exactly one cycle, A+1 cycles after the accepting edge. `rsp_data` then holds the value of `mem_data` at that edge. `mem_ce_n` and `mem_oe_n` return to 1 on the same edge.
- R6: `req_ready` returns to 1 R = ceil(50 ns/period) cycles after the `rsp_valid` cycle, so `mem_ce_n` stays high for at least R+1 cycles between accesses.
- R7: `grade` is sampled only on the accepting edge. A change while an access is in progress does not alter its timing.
- R8: `mem_oe_n` is never 0 while `mem_ce_n` is 1. Both enables are 1 whenever `req_ready` is 1 (standby).
- R9: `rsp_data` keeps the last returned word until the next `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grade | input | 2 | Speed class of the memory, sampled at acceptance |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | ADDR_W | Word address of the request |
| rsp_valid | output | 1 | One-cycle strobe: read word available |
| rsp_data | output | DATA_W | Read word |
| mem_addr | output | ADDR_W | Address to the memory |
| mem_ce_n | output | 1 | Device select, active low |
| mem_oe_n | output | 1 | Output gate, active low |
| mem_data | input | DATA_W | Data bus from the memory |

## Verification
The memory model in the bench returns the true word only after the select has been low and the address stable for A+1 half-cycle-offset samples, and the gate low for O+1. Outside that window it returns the inverted word. This makes a capture that is too early, a gate that opens too late or a moving address show up as wrong data, and such a fault is not hidden behind correct strobe timing. Directed accesses cover every grade including the aliased code 3, the lowest and highest addresses, a grade change in the middle of an access, and a request held during a busy access. Seeded random addresses and grades then check the gate, strobe and ready cycles against counts the bench derives from the nanosecond figures.

// File: rtl/amem_reader.sv
`timescale 1ns/1ps
module amem_reader #(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 16,
  parameter int CLK_PS   = 10000,
  parameter int TA0_PS   = 120000,
  parameter int TA1_PS   = 150000,
  parameter int TA2_PS   = 200000,
  parameter int TO0_PS   = 60000,
  parameter int TO1_PS   = 80000,
  parameter int TO2_PS   = 100000,
  parameter int TREL_PS  = 50000,
  parameter int CNT_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        grade,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  input  logic [DATA_W-1:0] mem_data
);
  localparam int A0 = (TA0_PS + CLK_PS - 1) / CLK_PS;
  localparam int A1 = (TA1_PS + CLK_PS - 1) / CLK_PS;
  localparam int A2 = (TA2_PS + CLK_PS - 1) / CLK_PS;
  localparam int O0 = (TO0_PS + CLK_PS - 1) / CLK_PS;
  localparam int O1 = (TO1_PS + CLK_PS - 1) / CLK_PS;
  localparam int O2 = (TO2_PS + CLK_PS - 1) / CLK_PS;
  localparam int RC = (TREL_PS + CLK_PS - 1) / CLK_PS;
  localparam int RL = (RC < 1) ? 0 : RC - 1;
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0] REL_LAST = CNT_W'(RL);

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_REL} st_t;
  st_t st;
  logic [CNT_W-1:0] cnt, lim_a, lim_os, sel_a, sel_os;

  always_comb begin
    case (grade)
      2'd0:    begin sel_a = CNT_W'(A0); sel_os = CNT_W'(A0 - O0); end
      2'd1:    begin sel_a = CNT_W'(A1); sel_os = CNT_W'(A1 - O1); end
      default: begin sel_a = CNT_W'(A2); sel_os = CNT_W'(A2 - O2); end
    endcase
  end

  assign req_ready = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      lim_a     <= '0;
      lim_os    <= '0;
      mem_addr  <= '0;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          mem_addr <= req_addr;
          mem_ce_n <= 1'b0;
          mem_oe_n <= (sel_os != '0);
          lim_a    <= sel_a;
          lim_os   <= sel_os;
          cnt      <= '0;
          st       <= S_ACC;
        end
        S_ACC: begin
          cnt <= cnt + ONE;
          if (cnt + ONE == lim_os) mem_oe_n <= 1'b0;
          if (cnt == lim_a) begin
            rsp_data  <= mem_data;
            rsp_valid <= 1'b1;
            mem_ce_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            cnt       <= '0;
            st        <= S_REL;
          end
        end
        default: begin
          if (cnt >= REL_LAST) st <= S_IDLE;
          else cnt <= cnt + ONE;
        end
      endcase
    end
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !mem_ce_n));
  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_close_on_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (mem_ce_n && mem_oe_n && !req_ready));
  assert_gate_under_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_ce_n);
  assert_standby_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_oe_n));
endmodule

// File: tb/amem_reader_test.sv
`timescale 1ns/1ps
module amem_reader_test;
  localparam int CLK_PS = 10000;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, req_valid, req_ready, rsp_valid, mem_ce_n, mem_oe_n;
  logic [1:0] grade;
  logic [17:0] req_addr, mem_addr;
  logic [15:0] rsp_data, mem_data;

  amem_reader uut (.clk(clk), .rst_n(rst_n), .grade(grade), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_data(mem_data));

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int acc_ns(int g);
    return (g == 0) ? 120 : (g == 1) ? 150 : 200;
  endfunction
  function automatic int oe_ns(int g);
    return (g == 0) ? 60 : (g == 1) ? 80 : 100;
  endfunction
  function automatic int cyc(int ns);
    return (ns * 1000 + CLK_PS - 1) / CLK_PS;
  endfunction
  function automatic logic [15:0] pattern(logic [17:0] a);
    return 16'(a * 18'd40503) ^ 16'(a >> 2) ^ 16'h5A5A;
  endfunction

  // memory model: true word only once both timing windows are met
  int cur_a = 0, cur_o = 0, ce_cnt = 0, oe_cnt = 0;
  logic [17:0] seen_addr = '0;
  always @(negedge clk) begin
    if (mem_ce_n) ce_cnt <= 0;
    else if (mem_addr == seen_addr) ce_cnt <= ce_cnt + 1;
    else ce_cnt <= 1;
    oe_cnt <= mem_oe_n ? 0 : oe_cnt + 1;
    seen_addr <= mem_addr;
  end
  assign mem_data = (ce_cnt >= cur_a + 1 && oe_cnt >= cur_o + 1) ? pattern(mem_addr) : ~pattern(mem_addr);

  task automatic run(logic [17:0] addr, int g, bit twiddle, bit busy_req);
    int a, o, r, k, k_oe, k_rsp, k_rdy, n_rsp;
    bit oe_bad, addr_bad;
    logic [15:0] got;
    while (!req_ready) @(negedge clk);
    a = cyc(acc_ns(g)); o = cyc(oe_ns(g)); r = cyc(50);
    cur_a = a; cur_o = o;
    req_valid = 1'b1; req_addr = addr; grade = 2'(g);
    @(negedge clk);
    req_valid = busy_req;
    if (busy_req) req_addr = ~addr;
    if (twiddle) grade = (g == 0) ? 2'd2 : 2'd0;
    chk(!mem_ce_n, "R3", "select low after accept", int'(mem_ce_n), 0);
    chk(mem_addr == addr, "R3", "address driven", int'(mem_addr), int'(addr));
    chk(!req_ready, "R2", "busy after accept", int'(req_ready), 0);
    k = 1; k_oe = -1; k_rsp = -1; k_rdy = -1; n_rsp = 0; oe_bad = 0; addr_bad = 0; got = '0;
    while (k < 300) begin
      if (!mem_oe_n && k_oe < 0) k_oe = k;
      if (!mem_oe_n && mem_ce_n) oe_bad = 1;
      if (k_rsp < 0 && mem_addr != addr) addr_bad = 1;
      if (rsp_valid) begin n_rsp++; if (k_rsp < 0) begin k_rsp = k; got = rsp_data; end end
      if (req_ready) begin k_rdy = k; break; end
      @(negedge clk); k++;
    end
    req_valid = 1'b0;
    chk(k_oe == a - o + 1, twiddle ? "R7" : "R4", "gate fall cycle", k_oe, a - o + 1);
    chk(k_rsp == a + 2, twiddle ? "R7" : "R5", "strobe cycle", k_rsp, a + 2);
    chk(n_rsp == 1, "R5", "strobe width", n_rsp, 1);
    chk(got == pattern(addr), "R5", "read word", int'(got), int'(pattern(addr)));
    chk(k_rdy == a + 2 + r, "R6", "ready return cycle", k_rdy, a + 2 + r);
    chk(!oe_bad && mem_ce_n && mem_oe_n, "R8", "gate under select / standby", int'(oe_bad), 0);
    chk(!addr_bad, "R3", "address stable", int'(addr_bad), 0);
    chk(rsp_data == pattern(addr), "R9", "word held", int'(rsp_data), int'(pattern(addr)));
    if (busy_req) begin
      repeat (3) @(negedge clk);
      chk(mem_ce_n && req_ready, "R2", "busy request ignored", int'(mem_ce_n), 1);
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; grade = '0;
    repeat (3) @(negedge clk);
    chk(req_ready && mem_ce_n && mem_oe_n && !rsp_valid, "R1", "state in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && mem_ce_n && mem_oe_n && !rsp_valid, "R1", "state after reset", int'(req_ready), 1);
    run(18'h00000, 0, 0, 0);
    run(18'h3FFFF, 1, 0, 0);
    run(18'h2A5A5, 2, 0, 0);
    run(18'h15A5A, 3, 0, 0);
    run(18'h01234, 0, 1, 0);
    run(18'h3C3C3, 2, 1, 0);
    run(18'h0BEEF, 1, 0, 1);
    void'($urandom(32'd2024));
    for (int i = 0; i < 40; i++)
      run(18'($urandom), int'($urandom % 4), bit'($urandom % 2), bit'($urandom % 2));
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule